// File: doc/BRIEF.md
# Bidirectional TFT Gate Scan Controller

This block produces the row-select scan for a thin-film-transistor panel gate driver with 258 gate rows. Two independent start streams are shifted side by side along a two-lane chain clocked by `scan_clk`. Each row then receives a two-bit level code (OFF, LOW or HIGH) that follows from its pair of chain bits, the split-pulse mode select and the phase of the scan clock. The two end rows follow a gentler rule.

A direction input picks the end of the chain where the scan enters. The start pair at the entry end is an input. The pair at the opposite end becomes an output that repeats the start streams 256 clock pulses later, so that a second device can be cascaded. Two active-low overrides force every row to HIGH or to OFF without waiting for a clock edge. The analog level shifters behind the pads take the level code as their only input.

Top module: `gscan_top`

## Requirements
- R1: An active-low asynchronous reset clears both chain lanes at once. While the chain is clear, every row code is OFF and both cascade outputs are 2'b00.
- R2: With `dir_rev_i` low, the value of `lo_start_i` present at rising clock edge k is held by row p (lane 0 from bit 0, lane 1 from bit 1) after edge k+p. `hi_start_i` has no effect on the rows.
- R3: With `dir_rev_i` high, the value of `hi_start_i` present at edge k is held by row 257-p after edge k+p. `lo_start_i` has no effect on the rows.
- R4: Exactly one start pair drives at any time. `hi_start_oe` is 1 for the low-to-high scan and `lo_start_oe` is 1 for the high-to-low scan. The non-driving pair's output reads 2'b00.
- R5: The driving pair's output, after edge k, equals the start input that entered the chain at edge k-255. The cascade copy is therefore 256 pulses behind the start.
- R6: Row r's code sits at `row_lvl_o[2r+1:2r]`, with 2'b00 = OFF, 2'b01 = LOW and 2'b10 = HIGH. For rows 1 to 256: both chain bits low gives OFF, exactly one high gives LOW, and both high with `split_i` low gives HIGH.
- R7: For rows 1 to 256 with both chain bits high and `split_i` high, the code is HIGH while `scan_clk` is low and LOW while `scan_clk` is high.
- R8: Rows 0 and 257 never show HIGH from the chain. Both bits high gives LOW, exactly one gives LOW, and none gives OFF.
- R9: While `force_hi_n_i` is low, every row is HIGH, whatever `force_off_n_i` is. The change takes effect without a clock edge.
- R10: While `force_hi_n_i` is high and `force_off_n_i` is low, every row is OFF. The change takes effect without a clock edge.
- R11: The scan direction is taken from `dir_rev_i` only at edges where the chain is clear. A change while the chain holds data does not alter the shift direction or the pin roles until the chain has emptied.
- R12: The overrides act on the outputs only. The chain keeps shifting under an override, and on release the rows show the chain's current state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| scan_clk | input | 1 | Scan clock; the chain advances on its rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| dir_rev_i | input | 1 | Scan direction: 0 = row 0 toward row 257, 1 = reverse |
| split_i | input | 1 | Split-pulse mode: HIGH rows drop to LOW during clock-high |
| force_hi_n_i | input | 1 | Active-low override forcing all rows HIGH |
| force_off_n_i | input | 1 | Active-low override forcing all rows OFF |
| lo_start_i | input | 2 | Start pair at the row-0 end (input side for the forward scan) |
| hi_start_i | input | 2 | Start pair at the row-257 end (input side for the reverse scan) |
| lo_start_o | output | 2 | Cascade value toward the row-0 end pad |
| lo_start_oe | output | 1 | Drive enable of the row-0 end pair |
| hi_start_o | output | 2 | Cascade value toward the row-257 end pad |
| hi_start_oe | output | 1 | Drive enable of the row-257 end pair |
| row_lvl_o | output | 516 | Per-row two-bit level code, row r at bits 2r+1:2r |

## Verification
Two pairs of functions can fall in the same cycle. An override can be held across clock edges while a start pulse is halfway down the chain, and a direction change can be requested while a scan is still travelling. The first is provoked by asserting each override between edges in the middle of a scan, keeping the OFF override across three edges, and releasing it. The judgement is that every row follows the override at once, and that after release the pulse sits exactly three rows further on. The second is provoked by flipping the direction input while data is in the chain. The judgement is that the rows keep moving the old way, the cascade output still appears on the old far pair at edge 256, and the pin roles swap only after the last bit has left.

// File: rtl/gscan_pkg.sv
package gscan_pkg;

  typedef enum logic [1:0] {
    LVL_OFF  = 2'b00,
    LVL_LOW  = 2'b01,
    LVL_HIGH = 2'b10
  } lvl_e;

  // Level of one row from its lane bits, before any override.
  function automatic lvl_e row_level(input logic b0, input logic b1,
                                     input logic split, input logic clk_hi,
                                     input logic end_row);
    if (!b0 && !b1) return LVL_OFF;
    if (b0 ^ b1) return LVL_LOW;
    if (end_row) return LVL_LOW;
    if (split && clk_hi) return LVL_LOW;
    return LVL_HIGH;
  endfunction

  // Row position of the cascade tap for a given direction.
  function automatic int tap_row(input int n_rows, input int lat, input bit rev);
    return rev ? (n_rows - lat) : (lat - 1);
  endfunction

endpackage

// File: rtl/gscan_dir_ctrl.sv
module gscan_dir_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic rev_req_i,
  input  logic idle_i,
  output logic rev_held_o,
  output logic rev_eff_o
);

  logic rev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rev_q <= 1'b0;
    end else if (idle_i) begin
      rev_q <= rev_req_i;
    end
  end

  // While the chain is clear the request applies at once; otherwise the held value rules.
  assign rev_eff_o  = idle_i ? rev_req_i : rev_q;
  assign rev_held_o = rev_q;

endmodule

// File: rtl/gscan_shift_lane.sv
module gscan_shift_lane #(
  parameter int N_ROWS = 258
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rev_i,
  input  logic              din_i,
  output logic [N_ROWS-1:0] q_o
);

  logic [N_ROWS-1:0] q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q <= '0;
    end else if (rev_i) begin
      q <= {din_i, q[N_ROWS-1:1]};
    end else begin
      q <= {q[N_ROWS-2:0], din_i};
    end
  end

  assign q_o = q;

endmodule

// File: rtl/gscan_level_map.sv
module gscan_level_map
  import gscan_pkg::*;
#(
  parameter int N_ROWS = 258
) (
  input  logic [N_ROWS-1:0]   lane0_i,
  input  logic [N_ROWS-1:0]   lane1_i,
  input  logic                split_i,
  input  logic                clk_i,
  input  logic                force_hi_n_i,
  input  logic                force_off_n_i,
  output logic [2*N_ROWS-1:0] lvl_o
);

  for (genvar r = 0; r < N_ROWS; r++) begin : g_row
    localparam bit END_ROW = (r == 0) || (r == N_ROWS - 1);
    lvl_e base;
    lvl_e final_lvl;

    assign base = row_level(lane0_i[r], lane1_i[r], split_i, clk_i, END_ROW);

    always_comb begin
      if (!force_hi_n_i)       final_lvl = LVL_HIGH;
      else if (!force_off_n_i) final_lvl = LVL_OFF;
      else                     final_lvl = base;
    end

    assign lvl_o[2*r +: 2] = final_lvl;
  end

endmodule

// File: rtl/gscan_top.sv
module gscan_top
  import gscan_pkg::*;
#(
  parameter int N_ROWS    = 258,
  parameter int CASC_LAT  = 256,
  parameter int N_LANES   = 2
) (
  input  logic                scan_clk,
  input  logic                rst_n,
  input  logic                dir_rev_i,
  input  logic                split_i,
  input  logic                force_hi_n_i,
  input  logic                force_off_n_i,
  input  logic [N_LANES-1:0]  lo_start_i,
  input  logic [N_LANES-1:0]  hi_start_i,
  output logic [N_LANES-1:0]  lo_start_o,
  output logic                lo_start_oe,
  output logic [N_LANES-1:0]  hi_start_o,
  output logic                hi_start_oe,
  output logic [2*N_ROWS-1:0] row_lvl_o
);

  localparam int TAP_FWD = tap_row(N_ROWS, CASC_LAT, 1'b0);
  localparam int TAP_REV = tap_row(N_ROWS, CASC_LAT, 1'b1);

  // Named internal events, also observed by the bound checker.
  logic                scan_idle;
  logic                dir_eff;
  logic                dir_held;
  logic [N_LANES-1:0]  row_first_bits;
  logic [N_LANES-1:0]  row_last_bits;
  logic [N_LANES-1:0]  casc_bits;
  logic [N_LANES-1:0]  lane_busy;

  logic [N_ROWS-1:0]   chain [N_LANES];

  gscan_dir_ctrl u_dir (
    .clk        (scan_clk),
    .rst_n      (rst_n),
    .rev_req_i  (dir_rev_i),
    .idle_i     (scan_idle),
    .rev_held_o (dir_held),
    .rev_eff_o  (dir_eff)
  );

  for (genvar g = 0; g < N_LANES; g++) begin : g_lane
    logic din;
    assign din = dir_eff ? hi_start_i[g] : lo_start_i[g];

    gscan_shift_lane #(.N_ROWS(N_ROWS)) u_lane (
      .clk   (scan_clk),
      .rst_n (rst_n),
      .rev_i (dir_eff),
      .din_i (din),
      .q_o   (chain[g])
    );

    assign lane_busy[g]      = |chain[g];
    assign row_first_bits[g] = chain[g][0];
    assign row_last_bits[g]  = chain[g][N_ROWS-1];
    assign casc_bits[g]      = dir_eff ? chain[g][TAP_REV] : chain[g][TAP_FWD];
  end

  assign scan_idle = ~|lane_busy;

  assign lo_start_oe = dir_eff;
  assign hi_start_oe = ~dir_eff;
  assign lo_start_o  = dir_eff ? casc_bits : '0;
  assign hi_start_o  = dir_eff ? '0 : casc_bits;

  gscan_level_map #(.N_ROWS(N_ROWS)) u_map (
    .lane0_i       (chain[0]),
    .lane1_i       (chain[1]),
    .split_i       (split_i),
    .clk_i         (scan_clk),
    .force_hi_n_i  (force_hi_n_i),
    .force_off_n_i (force_off_n_i),
    .lvl_o         (row_lvl_o)
  );

endmodule

// File: rtl/gscan_top_chk.sv
module gscan_top_chk #(
  parameter int N_ROWS = 258
) (
  input logic                scan_clk,
  input logic                rst_n,
  input logic                force_hi_n_i,
  input logic                force_off_n_i,
  input logic [1:0]          lo_start_i,
  input logic [1:0]          hi_start_i,
  input logic                lo_start_oe,
  input logic                hi_start_oe,
  input logic [2*N_ROWS-1:0] row_lvl_o,
  input logic                scan_idle,
  input logic                dir_eff,
  input logic                dir_held,
  input logic [1:0]          row_first_bits,
  input logic [1:0]          row_last_bits
);

  AST_FORCE_HIGH_ALL: assert property (@(posedge scan_clk) disable iff (!rst_n)
    !force_hi_n_i |-> row_lvl_o == {N_ROWS{2'b10}}); // R9

  AST_FORCE_OFF_ALL: assert property (@(posedge scan_clk) disable iff (!rst_n)
    (force_hi_n_i && !force_off_n_i) |-> row_lvl_o == '0); // R10

  AST_END_ROWS_NOT_HIGH: assert property (@(posedge scan_clk) disable iff (!rst_n)
    (force_hi_n_i && force_off_n_i) |->
      (row_lvl_o[1:0] != 2'b10) && (row_lvl_o[2*N_ROWS-1 -: 2] != 2'b10)); // R8

  AST_FWD_ENTRY: assert property (@(posedge scan_clk) disable iff (!rst_n)
    !dir_eff |=> row_first_bits == $past(lo_start_i)); // R2

  AST_REV_ENTRY: assert property (@(posedge scan_clk) disable iff (!rst_n)
    dir_eff |=> row_last_bits == $past(hi_start_i)); // R3

  AST_ONE_PAIR_DRIVES: assert property (@(posedge scan_clk) disable iff (!rst_n)
    $countones({lo_start_oe, hi_start_oe}) == 1); // R4

  AST_DIR_HELD_IN_SCAN: assert property (@(posedge scan_clk) disable iff (!rst_n)
    !scan_idle |=> $stable(dir_held)); // R11

endmodule

bind gscan_top gscan_top_chk #(.N_ROWS(N_ROWS)) u_chk (
  .scan_clk       (scan_clk),
  .rst_n          (rst_n),
  .force_hi_n_i   (force_hi_n_i),
  .force_off_n_i  (force_off_n_i),
  .lo_start_i     (lo_start_i),
  .hi_start_i     (hi_start_i),
  .lo_start_oe    (lo_start_oe),
  .hi_start_oe    (hi_start_oe),
  .row_lvl_o      (row_lvl_o),
  .scan_idle      (scan_idle),
  .dir_eff        (dir_eff),
  .dir_held       (dir_held),
  .row_first_bits (row_first_bits),
  .row_last_bits  (row_last_bits)
);

// File: tb/tb_gscan_top.sv
module tb_gscan_top;

  localparam int N = 258;
  localparam int LAT = 256;
  localparam int SCAN_EDGES = 270;
  localparam int N_SCANS = 6;
  localparam int WATCHDOG = 20000;

  // {rev, split, s0[3:0], l0[2:0], s1[3:0], l1[2:0]}
  localparam logic [15:0] SCANS [N_SCANS] = '{
    {1'b0, 1'b0, 4'd2, 3'd2, 4'd3, 3'd2},
    {1'b0, 1'b1, 4'd2, 3'd2, 4'd3, 3'd2},
    {1'b1, 1'b0, 4'd2, 3'd1, 4'd4, 3'd1},
    {1'b1, 1'b1, 4'd2, 3'd3, 4'd2, 3'd3},
    {1'b0, 1'b1, 4'd2, 3'd2, 4'd0, 3'd0},
    {1'b1, 1'b0, 4'd0, 3'd0, 4'd3, 3'd2}
  };

  logic scan_clk = 1'b0;
  logic rst_n, dir_rev_i, split_i, force_hi_n_i, force_off_n_i;
  logic [1:0] lo_start_i, hi_start_i, lo_start_o, hi_start_o;
  logic lo_start_oe, hi_start_oe;
  logic [2*N-1:0] row_lvl_o;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  always #10 scan_clk = ~scan_clk;

  gscan_top dut (
    .scan_clk(scan_clk), .rst_n(rst_n), .dir_rev_i(dir_rev_i), .split_i(split_i),
    .force_hi_n_i(force_hi_n_i), .force_off_n_i(force_off_n_i),
    .lo_start_i(lo_start_i), .hi_start_i(hi_start_i),
    .lo_start_o(lo_start_o), .lo_start_oe(lo_start_oe),
    .hi_start_o(hi_start_o), .hi_start_oe(hi_start_oe),
    .row_lvl_o(row_lvl_o)
  );

  function automatic bit pat(int s, int l, int e);
    return (e >= s) && (e < s + l);
  endfunction

  function automatic logic [1:0] exp_lvl(int r, bit b0, bit b1, bit spl, bit clk_hi);
    int n;
    n = int'(b0) + int'(b1);
    if (n == 0) return 2'b00;
    if (n == 1) return 2'b01;
    if (r == 0 || r == N - 1) return 2'b01;
    return (spl && clk_hi) ? 2'b01 : 2'b10;
  endfunction

  task automatic chk_rows(string tag, bit rev, bit spl, bit clk_hi, int e,
                          int s0, int l0, int s1, int l1);
    logic [2*N-1:0] exp;
    for (int r = 0; r < N; r++) begin
      int p;
      p = rev ? (N - 1 - r) : r;
      exp[2*r +: 2] = exp_lvl(r, pat(s0, l0, e - p), pat(s1, l1, e - p), spl, clk_hi);
    end
    checks++;
    if (row_lvl_o !== exp) begin
      errors++;
      for (int r = 0; r < N; r++) begin
        if (row_lvl_o[2*r +: 2] !== exp[2*r +: 2]) begin
          $display("FAIL %s edge %0d row %0d: actual %b expected %b", tag, e, r,
                   row_lvl_o[2*r +: 2], exp[2*r +: 2]);
          break;
        end
      end
    end
  endtask

  task automatic chk_all(string tag, logic [1:0] code);
    checks++;
    if (row_lvl_o !== {N{code}}) begin
      errors++;
      $display("FAIL %s all rows: actual row0=%b row257=%b expected %b", tag,
               row_lvl_o[1:0], row_lvl_o[2*N-1 -: 2], code);
    end
  endtask

  task automatic chk_val(string tag, logic [1:0] act, logic [1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %b expected %b", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge scan_clk);
    #15;
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  always @(posedge scan_clk) begin
    cyc++;
    if (cyc > WATCHDOG) begin
      errors++;
      $display("FAIL R1 watchdog: actual %0d cycles expected below %0d", cyc, WATCHDOG);
      finish_run();
    end
  end

  initial begin
    rst_n = 1'b0; dir_rev_i = 1'b0; split_i = 1'b0;
    force_hi_n_i = 1'b1; force_off_n_i = 1'b1;
    lo_start_i = 2'b00; hi_start_i = 2'b00;
    #5;
    // R1: reset state
    chk_all("R1 reset rows", 2'b00);
    chk_val("R1 reset lo cascade", lo_start_o, 2'b00);
    chk_val("R1 reset hi cascade", hi_start_o, 2'b00);
    @(posedge scan_clk); @(posedge scan_clk); #15;
    rst_n = 1'b1;

    // Table-driven scans: R2 R3 R4 R5 R6 R7 R8
    for (int i = 0; i < N_SCANS; i++) begin
      bit rev, spl;
      int s0, l0, s1, l1;
      rev = SCANS[i][15]; spl = SCANS[i][14];
      s0 = int'(SCANS[i][13:10]); l0 = int'(SCANS[i][9:7]);
      s1 = int'(SCANS[i][6:3]);   l1 = int'(SCANS[i][2:0]);
      dir_rev_i = rev; split_i = spl;
      for (int e = 1; e <= SCAN_EDGES; e++) begin
        logic [1:0] drv, casc;
        drv = {pat(s1, l1, e), pat(s0, l0, e)};
        if (rev) begin hi_start_i = drv; lo_start_i = 2'b11; end
        else     begin lo_start_i = drv; hi_start_i = 2'b11; end
        @(posedge scan_clk); #5;
        chk_rows(rev ? "R3/R6/R7/R8 clk-high" : "R2/R6/R7/R8 clk-high", rev, spl, 1'b1, e, s0, l0, s1, l1);
        #10;
        chk_rows(rev ? "R3/R6/R7/R8 clk-low" : "R2/R6/R7/R8 clk-low", rev, spl, 1'b0, e, s0, l0, s1, l1);
        casc = {pat(s1, l1, e - (LAT - 1)), pat(s0, l0, e - (LAT - 1))};
        chk_val("R5 cascade far pair", rev ? lo_start_o : hi_start_o, casc);
        chk_val("R4 near pair quiet", rev ? hi_start_o : lo_start_o, 2'b00);
        chk_val("R4 pin roles", {lo_start_oe, hi_start_oe}, rev ? 2'b10 : 2'b01);
      end
    end

    // Directed: overrides during a forward scan, then direction change mid-scan
    dir_rev_i = 1'b0; split_i = 1'b0; hi_start_i = 2'b00;
    lo_start_i = 2'b11; step();
    step();
    lo_start_i = 2'b00; step(); step(); step();
    chk_rows("R2 pre-override", 1'b0, 1'b0, 1'b0, 5, 1, 2, 1, 2);
    force_hi_n_i = 1'b0; #1;
    chk_all("R9 force high", 2'b10);
    force_off_n_i = 1'b0; #1;
    chk_all("R9 force high wins", 2'b10);
    force_hi_n_i = 1'b1; #1;
    chk_all("R10 force off", 2'b00);
    force_off_n_i = 1'b1; #1;
    chk_rows("R12 release same cycle", 1'b0, 1'b0, 1'b0, 5, 1, 2, 1, 2);
    force_off_n_i = 1'b0;
    for (int k = 0; k < 3; k++) begin
      @(posedge scan_clk); #5;
      chk_all("R10 held across edge", 2'b00);
      #10;
    end
    force_off_n_i = 1'b1; #1;
    chk_rows("R12 chain moved under override", 1'b0, 1'b0, 1'b0, 8, 1, 2, 1, 2);
    dir_rev_i = 1'b1;
    step();
    chk_rows("R11 direction held rows", 1'b0, 1'b0, 1'b0, 9, 1, 2, 1, 2);
    chk_val("R11 pin roles held", {lo_start_oe, hi_start_oe}, 2'b01);
    for (int e = 10; e <= 262; e++) begin
      step();
      if (e == 256 || e == 257) chk_val("R5 cascade after direction request", hi_start_o, 2'b11);
      if (e == 258) chk_val("R5 cascade ends", hi_start_o, 2'b00);
    end
    chk_val("R11 roles swap once clear", {lo_start_oe, hi_start_oe}, 2'b10);

    // Directed: asynchronous reset mid-scan
    dir_rev_i = 1'b0; step(); step();
    lo_start_i = 2'b11; step();
    lo_start_i = 2'b00; step(); step();
    rst_n = 1'b0; #1;
    chk_all("R1 async reset rows", 2'b00);
    chk_val("R1 async reset cascade", hi_start_o, 2'b00);
    #2;
    step();
    rst_n = 1'b1;
    step();
    chk_val("R1 roles after reset", {lo_start_oe, hi_start_oe}, 2'b01);
    chk_all("R1 rows stay clear", 2'b00);

    finish_run();
  end

endmodule